// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block decides which of five peripheral interrupt requests a small CPU core should take, and when it may take it. Each source is gated by its own enable bit and by a global enable. A per-source bit places it in the high or the low level. Inside a level, the lowest-numbered source wins. Two in-service latches, one per level, record which handlers are running. A running high-level handler blocks every new request. A running low-level handler blocks only low-level requests, so a high-level source can still nest on top of it.

The CPU reports on every cycle whether it is in the final machine cycle of an instruction. It also reports whether the instruction is a return-from-interrupt, or whether it touches the enable or level registers. Arbitration is only honoured on a clean final cycle. Any blocked poll is thrown away; nothing is stored, and the decision is made again from the current inputs on the next poll.

On acceptance the block raises a one-cycle vector request and presents a 16-bit handler address. The CPU then saves its program counter and jumps to that address. A return-from-interrupt issued on a final cycle releases the in-service latch of the level that is currently running.

Top module: `irq_arbiter`

## Requirements
- R1: Source index i (bit i of every mask: 0 ext-0, 1 timer-0, 2 ext-1, 3 timer-1, 4 serial) has handler address 8*i+3, giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R2: Among pending sources of the same level, the lowest index is accepted.
- R3: A pending high-level source (src_high bit = 1) beats every low-level one. With src_high = 5'b10100, ext-1 beats all others and timer-1 loses to all others.
- R4: Nothing is accepted unless last_cycle = 1. A request seen on a poll that is not a final cycle is not remembered.
- R5: Nothing is accepted in a cycle where insn_reti or reg_access is 1.
- R6: A source is considered only when both glob_en and its src_enable bit are 1.
- R7: Acceptance sets the latch of the winner's level. insvc_hi = 1 blocks all acceptance. insvc_lo = 1 blocks low-level acceptance only.
- R8: insn_reti with last_cycle = 1 clears insvc_hi if it is set, and otherwise clears insvc_lo.
- R9: After reset, vec_req, vec_addr, insvc_hi and insvc_lo are all 0.
- R10: vec_req and vec_addr are registered. They are valid in the cycle after the accepting clock edge, and vec_req lasts one cycle for each acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_flags | input | 5 | Pending request flags, one per source |
| src_enable | input | 5 | Per-source enable |
| glob_en | input | 1 | Global interrupt enable |
| src_high | input | 5 | Per-source level select, 1 = high |
| last_cycle | input | 1 | Final machine cycle of the current instruction |
| insn_reti | input | 1 | Current instruction is return-from-interrupt |
| reg_access | input | 1 | Current instruction accesses the enable or level register |
| vec_req | output | 1 | One-cycle request to push PC and jump |
| vec_addr | output | 16 | Handler address of the accepted source |
| insvc_hi | output | 1 | High-level handler in service |
| insvc_lo | output | 1 | Low-level handler in service |

## Verification
A wrong in-service latch shows up on the very next poll: acceptance is either missing or unexpected in the cycle after a final-cycle edge. Because of that, every sweep step reads insvc_hi and insvc_lo directly and then pairs each acceptance with a return. A bad priority or polling-order decode shows up as a wrong vec_addr one cycle after the poll. The full sweep of request patterns against level masks exposes it at once. A leaked deferral appears as a vec_req pulse following a non-final or return cycle.

// File: rtl/irq_arb_pkg.sv
// Package: shared sizes and the handler-address function for the interrupt arbiter.
// Assumes source index order equals the fixed polling order.
package irq_arb_pkg;
    localparam int NSRC       = 5;
    localparam int SRC_W      = $clog2(NSRC);
    localparam int ADDR_W     = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;

    // Handler address for a source index.
    function automatic logic [ADDR_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
        return ADDR_W'(VEC_BASE + VEC_STRIDE * int'(idx));
    endfunction
endpackage

// File: rtl/irq_prio_pick.sv
// Module: finds the lowest-index set bit of a candidate vector.
// Assumes lower index means earlier in the polling order.
module irq_prio_pick #(
    parameter int N = 5,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] cand,
    output logic         found,
    output logic [W-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_svc_track.sv
// Module: two in-service latches (high, low) with return-driven release.
// Assumes set and release never coincide (a return blocks acceptance).
module irq_svc_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_hi,
    input  logic set_lo,
    input  logic release_i,
    output logic busy_hi,
    output logic busy_lo
);
    // High latch: set on high acceptance, cleared first on return.
    always_ff @(posedge clk) begin
        if (!rst_n)                   busy_hi <= 1'b0;
        else if (release_i && busy_hi) busy_hi <= 1'b0;
        else if (set_hi)              busy_hi <= 1'b1;
    end

    // Low latch: cleared on return only when no high handler runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                    busy_lo <= 1'b0;
        else if (release_i && !busy_hi) busy_lo <= 1'b0;
        else if (set_lo)               busy_lo <= 1'b1;
    end

    // R8: a return with the high level running leaves it released
    p_hi_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(release_i && busy_hi) |-> !busy_hi);

    // R8: the low latch survives a return that released the high level
    p_lo_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(release_i && busy_hi && busy_lo) |-> busy_lo);

    // R7: a low handler never starts under a running high handler
    p_lo_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_lo) |-> !busy_hi);
endmodule

// File: rtl/irq_arbiter.sv
// Module: two-level interrupt arbiter, top level.
// Gates requests by enables, picks a winner per level, accepts on a clean
// final machine cycle and issues a registered vector request.
// Assumes the CPU clears the request flags itself.
module irq_arbiter
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_flags,
    input  logic [NSRC-1:0]   src_enable,
    input  logic              glob_en,
    input  logic [NSRC-1:0]   src_high,
    input  logic              last_cycle,
    input  logic              insn_reti,
    input  logic              reg_access,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              insvc_hi,
    output logic              insvc_lo
);
    localparam int NLVL = 2;

    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  cand  [NLVL];
    logic [NLVL-1:0]  found;
    logic [SRC_W-1:0] idx   [NLVL];
    logic             poll_ok, take_hi, take_lo, take_any, release_fire;
    logic [SRC_W-1:0] win_idx;

    // Request qualification and split into levels (index 1 = high).
    always_comb begin
        pend    = req_flags & src_enable & {NSRC{glob_en}};
        cand[1] = pend & src_high;
        cand[0] = pend & ~src_high;
    end

    // One polling-order picker per level.
    for (genvar lv = 0; lv < NLVL; lv++) begin : g_lvl
        irq_prio_pick #(.N(NSRC), .W(SRC_W)) pick_i (
            .cand  (cand[lv]),
            .found (found[lv]),
            .idx   (idx[lv])
        );
    end

    // Acceptance decision from poll window, level winners and latches.
    always_comb begin
        poll_ok      = last_cycle && !insn_reti && !reg_access;
        take_hi      = poll_ok && found[1] && !insvc_hi;
        take_lo      = poll_ok && !found[1] && found[0] && !insvc_hi && !insvc_lo;
        take_any     = take_hi || take_lo;
        win_idx      = take_hi ? idx[1] : idx[0];
        release_fire = last_cycle && insn_reti;
    end

    // Registered vector request and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_req  <= 1'b0;
            vec_addr <= '0;
        end else begin
            vec_req <= take_any;
            if (take_any) vec_addr <= vec_of(win_idx);
        end
    end

    irq_svc_track svc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_hi    (take_hi),
        .set_lo    (take_lo),
        .release_i (release_fire),
        .busy_hi   (insvc_hi),
        .busy_lo   (insvc_lo)
    );

    // R4: acceptance follows only a final-cycle poll
    p_final_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(last_cycle));

    // R5: no acceptance on a return or register-access instruction
    p_insn_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> !$past(insn_reti || reg_access));

    // R6: no acceptance with global enable clear
    p_global_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(glob_en));

    // R7: a running high handler blocks everything
    p_hi_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> !$past(insvc_hi));

    // R10: every acceptance leaves some level in service
    p_level_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (insvc_hi || insvc_lo));
endmodule

// File: tb/irq_arbiter_tb.sv
`timescale 1ns/1ps
module irq_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  req_flags, src_enable, src_high;
    logic        glob_en, last_cycle, insn_reti, reg_access;
    logic        vec_req, insvc_hi, insvc_lo;
    logic [15:0] vec_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    irq_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .req_flags(req_flags), .src_enable(src_enable),
        .glob_en(glob_en), .src_high(src_high), .last_cycle(last_cycle),
        .insn_reti(insn_reti), .reg_access(reg_access), .vec_req(vec_req),
        .vec_addr(vec_addr), .insvc_hi(insvc_hi), .insvc_lo(insvc_lo)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] rq, input logic [4:0] en, input logic ge,
                         input logic [4:0] hi, input logic lc, input logic rt, input logic ra);
        req_flags = rq; src_enable = en; glob_en = ge; src_high = hi;
        last_cycle = lc; insn_reti = rt; reg_access = ra;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Lowest set bit index, -1 when empty (R2 polling order).
    function automatic int lowest(input logic [4:0] v);
        for (int i = 0; i < 5; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8ns * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(5'h1f, 5'h1f, 1, 5'h00, 1, 0, 0);
        drive(5'h1f, 5'h1f, 1, 5'h00, 1, 0, 0);
        // R9 reset state
        chk("R9 vec_req", vec_req, 0);
        chk("R9 vec_addr", vec_addr, 0);
        chk("R9 insvc", {insvc_hi, insvc_lo}, 0);
        rst_n = 1'b1;
        drive(0, 5'h1f, 1, 0, 0, 0, 0);

        // R1 R2 R3 R7 R8 R10: sweep every request pattern against every level mask
        for (int r = 0; r < 32; r++) begin
            for (int p = 0; p < 32; p++) begin
                int hw, lw, w;
                hw = lowest(5'(r) & 5'(p));
                lw = lowest(5'(r) & ~5'(p));
                w  = (hw >= 0) ? hw : lw;
                drive(5'(r), 5'h1f, 1, 5'(p), 1, 0, 0);
                chk("R10 vec_req", vec_req, (w >= 0));
                if (w >= 0) chk("R1/R2/R3 vec_addr", vec_addr, 8 * w + 3);
                chk("R7 latch", {insvc_hi, insvc_lo}, {hw >= 0, (hw < 0) && (lw >= 0)});
                drive(0, 5'h1f, 1, 5'(p), 1, 1, 0);
                chk("R10 one pulse", vec_req, 0);
                chk("R8 release", {insvc_hi, insvc_lo}, 0);
            end
        end

        // R3 named case: level mask 10100
        drive(5'h1f, 5'h1f, 1, 5'b10100, 1, 0, 0);
        chk("R3 ext1 wins", vec_addr, 16'h0013);
        drive(0, 5'h1f, 1, 5'b10100, 1, 1, 0);
        drive(5'b01011, 5'h1f, 1, 5'b10100, 1, 0, 0);
        chk("R3 timer1 loses", vec_addr, 16'h0003);
        drive(0, 5'h1f, 1, 5'b10100, 1, 1, 0);

        // R6: enable mask sweep, global enable off
        for (int e = 0; e < 32; e++) begin
            drive(5'h1f, 5'(e), 1, 0, 1, 0, 0);
            chk("R6 enable gate", vec_req, (e != 0));
            if (e != 0) chk("R6 enable addr", vec_addr, 8 * lowest(5'(e)) + 3);
            drive(0, 5'h1f, 1, 0, 1, 1, 0);
        end
        drive(5'h1f, 5'h1f, 0, 5'h1f, 1, 0, 0);
        chk("R6 global off", {vec_req, insvc_hi, insvc_lo}, 0);

        // R4: non-final poll deferred and forgotten
        drive(5'b00100, 5'h1f, 1, 0, 0, 0, 0);
        chk("R4 not final", {vec_req, insvc_lo}, 0);
        drive(0, 5'h1f, 1, 0, 1, 0, 0);
        chk("R4 not remembered", vec_req, 0);

        // R5: return and register access block
        drive(5'b00010, 5'h1f, 1, 0, 1, 1, 0);
        chk("R5 reti blocks", vec_req, 0);
        drive(5'b00010, 5'h1f, 1, 0, 1, 0, 1);
        chk("R5 reg access blocks", vec_req, 0);
        drive(5'b00010, 5'h1f, 1, 0, 1, 0, 0);
        chk("R5 later poll", vec_addr, 16'h000B);
        drive(0, 5'h1f, 1, 0, 1, 1, 0);

        // R7/R8 nesting with ext0 high
        drive(5'b00010, 5'h1f, 1, 5'b00001, 1, 0, 0);
        chk("R7 low taken", {insvc_hi, insvc_lo}, 2'b01);
        drive(5'b00110, 5'h1f, 1, 5'b00001, 1, 0, 0);
        chk("R7 low blocks low", vec_req, 0);
        drive(5'b00001, 5'h1f, 1, 5'b00001, 1, 0, 0);
        chk("R7 high nests", {vec_req, vec_addr}, {1'b1, 16'h0003});
        chk("R7 both busy", {insvc_hi, insvc_lo}, 2'b11);
        drive(5'b00011, 5'h1f, 1, 5'b00001, 1, 0, 0);
        chk("R7 high blocks all", vec_req, 0);
        drive(0, 5'h1f, 1, 5'b00001, 0, 1, 0);
        chk("R8 needs final cycle", {insvc_hi, insvc_lo}, 2'b11);
        drive(0, 5'h1f, 1, 5'b00001, 1, 1, 0);
        chk("R8 high released first", {insvc_hi, insvc_lo}, 2'b01);
        drive(0, 5'h1f, 1, 5'b00001, 1, 1, 0);
        chk("R8 low released", {insvc_hi, insvc_lo}, 2'b00);

        finish_run();
    end
endmodule